// File: doc/BRIEF.md
# Triggered Event Pattern Player

This block plays stored test events out of a local pattern memory. The memory is split into four equal event buffers of 256 entries each. Every entry holds a data field and a 4-bit control field, so a buffer reads as a short command stream. An entry can be a data word to send, a wait before the first word, a wait between words, an empty-event marker, or an end-of-event marker.

A trigger carries a buffer number. It goes into a small pending queue. A walker state machine pops the queue, steps through the chosen buffer from slot 0, and pushes data words into an output FIFO. The FIFO drains through a valid/ready output port. Software or a test sequencer fills the memory beforehand through a single-word write port.

The walker has three states. `ST_IDLE` goes to `ST_RUN` when a trigger is pending; it pops the queue and selects slot 0 of that buffer. `ST_RUN` stays in `ST_RUN` on a data word, whether the word is pushed or the FIFO is full. It also stays in `ST_RUN` on a delay entry of 0 or 1. It goes to `ST_DELAY` on a delay entry above 1. It goes back to `ST_IDLE` on a terminating entry, or when it consumes the last slot of the buffer. `ST_DELAY` counts down and returns to `ST_RUN` when the count reaches zero.

Top module: `evt_pattern_tx`

## Requirements
- R1: After reset, `out_valid`, `trig_ovf_err` and `overrun_err` are 0.
- R2: A control value of 4'b0000 is a data word, and data words are sent in slot order. Take an idle block with an empty output FIFO and `out_ready` high. If a trigger is sampled at edge k and slot 0 is a data word, that word is presented right after edge k+2. Adjacent data words appear on consecutive cycles.
- R3: `wr_addr[9:8]` selects the buffer and `wr_addr[7:0]` selects the slot. A trigger with `trig_buf` = b plays buffer b starting at slot 0.
- R4: Control 4'b0001 is a latency entry whose delay N is the data field. If it is in slot 0, the first data word appears max(N,1) cycles later than it would without the entry.
- R5: Control 4'b0010 is a gap entry whose delay N is the data field. Placed between two data words, it leaves exactly max(N,1) idle cycles between them when `out_ready` is high.
- R6: Control 4'b0100 marks an empty event. It sends nothing, ends playback, and the next pending trigger is then served.
- R7: Control 4'b1000 ends the event, and no later slot is sent. Any entry with bit 2 or bit 3 set terminates the event, even if bit 0 or bit 1 is also set.
- R8: Triggers that arrive during playback wait in a 4-entry queue and are served in arrival order. A trigger that finds 4 pending entries is dropped and sets the sticky `trig_ovf_err`.
- R9: Consuming a non-terminating entry in slot 255 ends the event and sets the sticky `overrun_err`. A delay in slot 255 is not waited out.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. The walker stalls while the 4-entry output FIFO is full, and no word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Pattern memory write strobe |
| wr_addr | input | 10 | Write address {buffer, slot} |
| wr_ctrl | input | 4 | Control field of the written entry |
| wr_data | input | 16 | Data field of the written entry |
| trig_valid | input | 1 | Trigger accept strobe |
| trig_buf | input | 2 | Buffer number carried by the trigger |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | Output word available |
| out_data | output | 16 | Output word |
| trig_ovf_err | output | 1 | Sticky: a trigger was dropped on a full queue |
| overrun_err | output | 1 | Sticky: an event ran past its buffer end |

## Verification
The hardest states to reach from the ports are a full trigger queue and a buffer overrun. The queue only fills when triggers arrive faster than events finish. The bench therefore issues six triggers on consecutive cycles and mixes a short event with a long delayed one, so the sixth trigger lands while four are still pending. The overrun needs a buffer with no terminator anywhere in its 256 slots. The bench writes one such buffer and drains it with `out_ready` low one cycle in three, so the output FIFO fills and the walker stalls on the way to the last slot. A behavioural queue model, stepped on every clock, predicts every output word and both error flags.

// File: rtl/evtx_pkg.sv
package evtx_pkg;

    localparam int CTRL_W   = 4;
    localparam int CB_LAT   = 0;
    localparam int CB_GAP   = 1;
    localparam int CB_EMPTY = 2;
    localparam int CB_EOE   = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DELAY
    } walk_state_e;

    typedef enum logic [1:0] {
        EK_DATA,
        EK_DELAY,
        EK_STOP
    } entry_kind_e;

    // Terminators outrank delays; all-zero control is a data word.
    function automatic entry_kind_e classify(input logic [CTRL_W-1:0] c);
        if (c[CB_EOE] || c[CB_EMPTY]) begin
            return EK_STOP;
        end else if (c[CB_LAT] || c[CB_GAP]) begin
            return EK_DELAY;
        end else begin
            return EK_DATA;
        end
    endfunction

endpackage

// File: rtl/evtx_fifo.sv
module evtx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wp] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/evtx_ram.sv
module evtx_ram #(
    parameter int W       = 20,
    parameter int ENTRIES = 1024
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(ENTRIES)-1:0] waddr,
    input  logic [W-1:0]               wdata,
    input  logic [$clog2(ENTRIES)-1:0] raddr,
    output logic [W-1:0]               rdata
);
    logic [W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/evtx_walker.sv
module evtx_walker
    import evtx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BUF_W  = 2,
    parameter int OFF_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    q_empty,
    input  logic [BUF_W-1:0]        q_buf,
    output logic                    q_pop,
    output logic [BUF_W+OFF_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0]       rd_data,
    input  logic [CTRL_W-1:0]       rd_ctrl,
    input  logic                    of_full,
    output logic                    of_push,
    output logic [DATA_W-1:0]       of_data,
    output logic                    overrun_err
);
    localparam logic [OFF_W-1:0] LAST_OFF = '1;

    walk_state_e        state;
    walk_state_e        state_nx;
    entry_kind_e        kind;
    logic [BUF_W-1:0]   cur_buf;
    logic [OFF_W-1:0]   cur_off;
    logic [DATA_W-1:0]  dly_cnt;
    logic               adv;
    logic               load_dly;
    logic               ovr_hit;

    assign kind    = classify(rd_ctrl);
    assign rd_addr = {cur_buf, cur_off};
    assign of_data = rd_data;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_nx = state;
        q_pop    = 1'b0;
        of_push  = 1'b0;
        adv      = 1'b0;
        load_dly = 1'b0;
        ovr_hit  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (!q_empty) begin
                    q_pop    = 1'b1;
                    state_nx = ST_RUN;
                end
            end
            ST_RUN: begin
                unique case (kind)
                    EK_STOP: state_nx = ST_IDLE;
                    EK_DATA: begin
                        if (!of_full) begin
                            of_push = 1'b1;
                            adv     = 1'b1;
                        end
                    end
                    EK_DELAY: begin
                        adv = 1'b1;
                        if (rd_data > DATA_W'(1)) begin
                            load_dly = 1'b1;
                            state_nx = ST_DELAY;
                        end
                    end
                    default: state_nx = ST_IDLE;
                endcase
                if (adv && (cur_off == LAST_OFF)) begin
                    ovr_hit  = 1'b1;
                    load_dly = 1'b0;
                    state_nx = ST_IDLE;
                end
            end
            ST_DELAY: begin
                if (dly_cnt == '0) begin
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Walk pointer, delay counter, sticky overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_buf     <= '0;
            cur_off     <= '0;
            dly_cnt     <= '0;
            overrun_err <= 1'b0;
        end else begin
            if (q_pop) begin
                cur_buf <= q_buf;
                cur_off <= '0;
            end else if (adv) begin
                cur_off <= cur_off + 1'b1;
            end
            if (load_dly) begin
                dly_cnt <= rd_data - DATA_W'(2);
            end else if ((state == ST_DELAY) && (dly_cnt != '0)) begin
                dly_cnt <= dly_cnt - 1'b1;
            end
            if (ovr_hit) begin
                overrun_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/evt_pattern_tx.sv
module evt_pattern_tx
    import evtx_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_BUF   = 4,
    parameter int BUF_DEPTH = 256,
    parameter int TQ_DEPTH  = 4,
    parameter int OF_DEPTH  = 4
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         wr_en,
    input  logic [$clog2(NUM_BUF)+$clog2(BUF_DEPTH)-1:0] wr_addr,
    input  logic [3:0]                                   wr_ctrl,
    input  logic [DATA_W-1:0]                            wr_data,
    input  logic                                         trig_valid,
    input  logic [$clog2(NUM_BUF)-1:0]                   trig_buf,
    input  logic                                         out_ready,
    output logic                                         out_valid,
    output logic [DATA_W-1:0]                            out_data,
    output logic                                         trig_ovf_err,
    output logic                                         overrun_err
);
    localparam int BUF_W   = $clog2(NUM_BUF);
    localparam int OFF_W   = $clog2(BUF_DEPTH);
    localparam int ADDR_W  = BUF_W + OFF_W;
    localparam int ENTRIES = NUM_BUF * BUF_DEPTH;
    localparam int WORD_W  = CTRL_W + DATA_W;

    logic               tq_push;
    logic               tq_full;
    logic               tq_empty;
    logic               q_pop;
    logic [BUF_W-1:0]   q_buf;
    logic [ADDR_W-1:0]  rd_addr;
    logic [WORD_W-1:0]  rd_word;
    logic               of_push;
    logic               of_full;
    logic               of_empty;
    logic [DATA_W-1:0]  of_din;

    assign tq_push = trig_valid && !tq_full;

    evtx_fifo #(.W(BUF_W), .DEPTH(TQ_DEPTH)) u_trig_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tq_push),
        .din   (trig_buf),
        .pop   (q_pop),
        .dout  (q_buf),
        .empty (tq_empty),
        .full  (tq_full)
    );

    evtx_ram #(.W(WORD_W), .ENTRIES(ENTRIES)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata ({wr_ctrl, wr_data}),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    evtx_walker #(.DATA_W(DATA_W), .BUF_W(BUF_W), .OFF_W(OFF_W)) u_walker (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_empty     (tq_empty),
        .q_buf       (q_buf),
        .q_pop       (q_pop),
        .rd_addr     (rd_addr),
        .rd_data     (rd_word[DATA_W-1:0]),
        .rd_ctrl     (rd_word[WORD_W-1:DATA_W]),
        .of_full     (of_full),
        .of_push     (of_push),
        .of_data     (of_din),
        .overrun_err (overrun_err)
    );

    evtx_fifo #(.W(DATA_W), .DEPTH(OF_DEPTH)) u_out_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (of_push),
        .din   (of_din),
        .pop   (out_ready),
        .dout  (out_data),
        .empty (of_empty),
        .full  (of_full)
    );

    assign out_valid = !of_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_ovf_err <= 1'b0;
        end else if (trig_valid && tq_full) begin
            trig_ovf_err <= 1'b1;
        end
    end

endmodule

// File: rtl/evtx_checker.sv
module evtx_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig_valid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              trig_ovf_err,
    input logic              overrun_err,
    input logic              of_push,
    input logic              of_full,
    input logic              q_pop,
    input logic              tq_empty
);

    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_no_push_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        of_push |-> !of_full);

    assert_pop_only_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> !tq_empty);

    assert_trig_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ovf_err |=> trig_ovf_err);

    assert_trig_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_ovf_err) |-> $past(trig_valid));

    assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |=> overrun_err);

endmodule

bind evt_pattern_tx evtx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_valid   (trig_valid),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .trig_ovf_err (trig_ovf_err),
    .overrun_err  (overrun_err),
    .of_push      (of_push),
    .of_full      (of_full),
    .q_pop        (q_pop),
    .tq_empty     (tq_empty)
);

// File: tb/evt_pattern_tx_bench.sv
module evt_pattern_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [9:0]    wr_addr = '0;
    logic [3:0]    wr_ctrl = '0;
    logic [DW-1:0] wr_data = '0;
    logic          trig_valid = 1'b0;
    logic [1:0]    trig_buf = '0;
    logic          out_ready = 1'b1;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          trig_ovf_err;
    logic          overrun_err;

    evt_pattern_tx u_evt_pattern_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_ctrl(wr_ctrl), .wr_data(wr_data), .trig_valid(trig_valid),
        .trig_buf(trig_buf), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .trig_ovf_err(trig_ovf_err), .overrun_err(overrun_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    checks = 0;
    int    failures = 0;
    int    words_seen = 0;
    bit    done = 0;
    string cur_req = "R2";

    // Behavioural reference model
    int          m_state = 0;   // 0 idle, 1 walking, 2 waiting
    int          m_buf = 0;
    int          m_off = 0;
    int          m_left = 0;
    int          tq[$];
    int          ofq[$];
    bit          m_terr = 0;
    bit          m_oerr = 0;
    logic [19:0] mmem [0:1023];
    int          tq_n, of_n, dat;
    logic [3:0]  c;
    bit          adv;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_off = 0; m_left = 0; m_terr = 0; m_oerr = 0;
            tq.delete(); ofq.delete();
        end else begin
            tq_n = tq.size();
            of_n = ofq.size();
            if (out_ready && of_n > 0) void'(ofq.pop_front());
            case (m_state)
                0: if (tq_n > 0) begin m_buf = tq.pop_front(); m_off = 0; m_state = 1; end
                1: begin
                    c   = mmem[m_buf*256 + m_off][19:16];
                    dat = int'(mmem[m_buf*256 + m_off][15:0]);
                    if (c[3] || c[2]) m_state = 0;
                    else begin
                        adv = 0;
                        if (c[0] || c[1]) begin
                            adv = 1;
                            if (dat > 1) begin m_left = dat - 1; m_state = 2; end
                        end else if (of_n < 4) begin
                            ofq.push_back(dat); adv = 1;
                        end
                        if (adv) begin
                            if (m_off == 255) begin m_oerr = 1; m_state = 0; end
                            else m_off++;
                        end
                    end
                end
                default: begin m_left--; if (m_left == 0) m_state = 1; end
            endcase
            if (trig_valid) begin
                if (tq_n < 4) tq.push_back(int'(trig_buf));
                else m_terr = 1;
            end
            if (wr_en) mmem[wr_addr] = {wr_ctrl, wr_data};
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(out_valid == (ofq.size() > 0), cur_req, "out_valid", out_valid, ofq.size() > 0);
            if (out_valid && ofq.size() > 0)
                chk(out_data == ofq[0][15:0], cur_req, "out_data", out_data, ofq[0]);
            chk(trig_ovf_err == m_terr, "R8", "trig_ovf_err", trig_ovf_err, m_terr);
            chk(overrun_err == m_oerr, "R9", "overrun_err", overrun_err, m_oerr);
            if (out_valid && out_ready) words_seen++;
        end
    end

    task automatic wr(input int a, input logic [3:0] cc, input int d);
        wr_en = 1; wr_addr = 10'(a); wr_ctrl = cc; wr_data = DW'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic trig(input int b);
        trig_valid = 1; trig_buf = 2'(b);
        @(negedge clk);
        trig_valid = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(m_state == 0 && tq.size() == 0 && ofq.size() == 0));
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        chk(trig_ovf_err == 0, "R1", "trig_ovf_err after reset", trig_ovf_err, 0);
        chk(overrun_err == 0, "R1", "overrun_err after reset", overrun_err, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int w0;
        int hits[$];
        int exp_idx[5] = '{7, 11, 13, 15, 18};
        int cyc;
        @(negedge clk);
        do_reset();

        // R3: buffer layout {buffer, slot}
        wr(10'h000, 4'b0000, 16'hA001); wr(10'h001, 4'b0000, 16'hA002);
        wr(10'h002, 4'b0000, 16'hA003); wr(10'h003, 4'b1000, 0);
        wr(10'h004, 4'b0000, 16'hDEAD);
        wr(10'h100, 4'b0001, 5);        wr(10'h101, 4'b0000, 16'hB001);
        wr(10'h102, 4'b0010, 3);        wr(10'h103, 4'b0000, 16'hB002);
        wr(10'h104, 4'b0010, 0);        wr(10'h105, 4'b0000, 16'hB003);
        wr(10'h106, 4'b0010, 1);        wr(10'h107, 4'b0000, 16'hB004);
        wr(10'h108, 4'b0010, 2);        wr(10'h109, 4'b0000, 16'hB005);
        wr(10'h10A, 4'b1000, 0);
        wr(10'h200, 4'b0100, 0);        wr(10'h201, 4'b0000, 16'h2222);
        wr(10'h300, 4'b1001, 5);        wr(10'h301, 4'b0000, 16'h3333);

        // R2 first word timing, R3 buffer 0, R7 end marker stops playback
        cur_req = "R2";
        w0 = words_seen;
        trig(0);
        hits.delete();
        for (int j = 1; j <= 12; j++) begin
            @(negedge clk); #2;
            if (out_valid) hits.push_back(j);
        end
        @(negedge clk);
        chk(hits.size() > 0 && hits[0] == 2, "R2", "first word edge", hits.size() > 0 ? hits[0] : -1, 2);
        chk(hits.size() == 3 && hits[2] == 4, "R2", "consecutive words", hits.size(), 3);
        wait_idle();
        chk(words_seen - w0 == 3, "R7", "words before end marker", words_seen - w0, 3);

        // R4 latency, R5 gaps, R3 buffer 1
        cur_req = "R5";
        trig(1);
        hits.delete();
        for (int j = 1; j <= 30; j++) begin
            @(negedge clk); #2;
            if (out_valid) hits.push_back(j);
        end
        @(negedge clk);
        chk(hits.size() == 5, "R3", "buffer 1 word count", hits.size(), 5);
        if (hits.size() == 5) begin
            chk(hits[0] == exp_idx[0], "R4", "latency 5 first word edge", hits[0], exp_idx[0]);
            for (int i = 1; i < 5; i++)
                chk(hits[i] == exp_idx[i], "R5", "gap word edge", hits[i], exp_idx[i]);
        end
        wait_idle();

        // R6 empty event, then the next trigger is served
        cur_req = "R6";
        w0 = words_seen;
        trig(2);
        repeat (20) @(negedge clk);
        chk(words_seen == w0, "R6", "empty event words", words_seen - w0, 0);
        trig(0);
        wait_idle();
        chk(words_seen - w0 == 3, "R6", "trigger after empty event", words_seen - w0, 3);

        // R7 terminator bits outrank delay bits
        cur_req = "R7";
        w0 = words_seen;
        trig(3);
        repeat (20) @(negedge clk);
        chk(words_seen == w0, "R7", "mixed terminator words", words_seen - w0, 0);

        // R8 queue order and overflow
        cur_req = "R8";
        w0 = words_seen;
        trig(0); trig(1); trig(0); trig(1); trig(0); trig(0);
        wait_idle();
        chk(trig_ovf_err == 1, "R8", "overflow flag", trig_ovf_err, 1);
        chk(words_seen - w0 == 19, "R8", "queued words", words_seen - w0, 19);

        // R10 hold under backpressure
        cur_req = "R10";
        out_ready = 0;
        trig(0);
        repeat (10) @(negedge clk);
        #2;
        chk(out_valid == 1, "R10", "valid held", out_valid, 1);
        chk(out_data == 16'hA001, "R10", "data held", out_data, 16'hA001);
        @(negedge clk);
        w0 = words_seen;
        out_ready = 1;
        wait_idle();
        chk(words_seen - w0 == 3, "R10", "words after release", words_seen - w0, 3);

        // R9 overrun on a buffer without terminator, R10 stalls on full FIFO
        cur_req = "R9";
        for (int i = 0; i < 256; i++) wr(768 + i, 4'b0000, 16'h3000 + i);
        w0 = words_seen;
        trig(3);
        cyc = 0;
        while (!(m_state == 0 && tq.size() == 0 && ofq.size() == 0)) begin
            out_ready = (cyc % 3) != 0;
            cyc++;
            @(negedge clk);
        end
        out_ready = 1;
        wait_idle();
        chk(words_seen - w0 == 256, "R9", "overrun words", words_seen - w0, 256);
        chk(overrun_err == 1, "R9", "overrun flag", overrun_err, 1);
        chk(trig_ovf_err == 1, "R8", "overflow flag stays", trig_ovf_err, 1);

        // R1 reset clears sticky flags
        do_reset();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule